// File: doc/BRIEF.md
# Reset and Boot Sequencing Controller

This block takes a processor core from reset to its first instruction fetch. When the reset input is released it runs a fixed sequence. A power-on reset first waits a long clock-settling interval, while a warm reset skips that wait. The block then gives one cycle of initialization strobes, which empty the stack pointers, mask every interrupt and clear the mode/status register. It can then start an external boot loader and wait for it to finish. Last, it enables instruction fetch from a fixed start address.

Two things decide whether a boot load happens: a boot-mode strap, and whether an external bus master holds a request when the decision is due. While a bus request is pending the controller stays in a bus-held state. When the request drops it makes the boot decision. Pulling the reset input low at any time returns the controller to its idle reset state at once.

Top module: `reset_boot_seq`

## Requirements
- R1: While `rst_n` is low, every output is low: all strobes, `boot_start` and `fetch_en`, and `fetch_addr` reads zero.
- R2: When `por` is high as reset is released, the three init strobes appear in clock cycle HOLD_CYCLES+1 after release (cycle 2001 with the default of 2000).
- R3: When `por` is low as reset is released, the init strobes appear in the first clock cycle after release.
- R4: `clr_stacks`, `mask_irqs` and `clr_mode` are high together, for exactly one cycle per reset release.
- R5: If `bus_req` is high at the clock edge that ends the strobe cycle, the controller waits. The boot decision takes effect in the cycle after the first edge at which `bus_req` is sampled low.
- R6: With `boot_strap` = 0 (boot selected), `boot_start` pulses for exactly one cycle at the decision point. Its decision edge saw `bus_req` low and the strap at 0.
- R7: After `boot_start`, `fetch_en` rises in the cycle after the first edge at which `boot_done` is sampled high. A `boot_done` that is high during the `boot_start` cycle is ignored.
- R8: With `boot_strap` = 1 (no boot), `boot_start` never pulses, and `fetch_en` rises at the decision point itself.
- R9: Once high, `fetch_en` stays high until reset, and `fetch_addr` then equals START_ADDR (default 0).
- R10: Pulling `rst_n` low in the middle of a sequence or during fetch drops `fetch_en` and `boot_start` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| por | input | 1 | High when the current reset is a power-on reset |
| boot_strap | input | 1 | 0 selects a boot load, 1 skips it |
| bus_req | input | 1 | External bus request pending |
| boot_done | input | 1 | Boot loader has finished |
| clr_stacks | output | 1 | One-cycle strobe: empty all stack pointers |
| mask_irqs | output | 1 | One-cycle strobe: mask all interrupts |
| clr_mode | output | 1 | One-cycle strobe: clear the mode/status register |
| boot_start | output | 1 | One-cycle pulse that starts the boot loader |
| fetch_en | output | 1 | Instruction fetch enabled |
| fetch_addr | output | ADDR_W | First fetch address, valid while fetch_en is high |

## Verification
The bench sweeps every combination of reset kind (power-on or warm), strap value, bus request (absent, or held past the strobe cycle) and boot-done delay (asserted early, or several cycles late). For each combination it predicts, by arithmetic, the cycles in which the strobes, the boot pulse and the fetch enable appear. Reset kind separates the long wait from the short path. The bus pattern shows whether the boot decision is held back. The early boot-done shows that the signal is ignored before the wait state, while the late one shows the controller waiting for it. Resets applied during boot wait and during fetch show that the asynchronous return to idle works.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [2:0] {
    ST_RESET, ST_LOCK, ST_INIT, ST_BUSHOLD, ST_KICK, ST_LOADWAIT, ST_RUN
  } seq_state_e;

  // width of a counter that must reach n-1
  function automatic int unsigned lock_cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // strap value 0 requests a boot load
  function automatic logic boot_wanted(logic strap);
    return (strap == 1'b0);
  endfunction

  // target after the init strobes once the bus is free
  function automatic seq_state_e after_init(logic strap);
    return boot_wanted(strap) ? ST_KICK : ST_RUN;
  endfunction
endpackage

// File: rtl/rbs_hold_timer.sv
module rbs_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  import rbs_pkg::*;
  localparam int unsigned CW = lock_cnt_w(HOLD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (!done)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/rbs_seq_fsm.sv
module rbs_seq_fsm
  import rbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por,
  input  logic       boot_strap,
  input  logic       bus_req,
  input  logic       boot_done,
  input  logic       hold_done,
  output seq_state_e state
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:    nxt = por ? ST_LOCK : ST_INIT;
      ST_LOCK:     if (hold_done) nxt = ST_INIT;
      ST_INIT,
      ST_BUSHOLD:  nxt = bus_req ? ST_BUSHOLD : after_init(boot_strap);
      ST_KICK:     nxt = ST_LOADWAIT;
      ST_LOADWAIT: if (boot_done) nxt = ST_RUN;
      ST_RUN:      nxt = ST_RUN;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end
endmodule

// File: rtl/rbs_out_decode.sv
module rbs_out_decode
  import rbs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned START_ADDR = 0
) (
  input  seq_state_e        state,
  output logic              clr_stacks,
  output logic              mask_irqs,
  output logic              clr_mode,
  output logic              boot_start,
  output logic              fetch_en,
  output logic [ADDR_W-1:0] fetch_addr
);
  logic init_cyc;
  assign init_cyc   = (state == ST_INIT);
  assign clr_stacks = init_cyc;
  assign mask_irqs  = init_cyc;
  assign clr_mode   = init_cyc;
  assign boot_start = (state == ST_KICK);
  assign fetch_en   = (state == ST_RUN);
  assign fetch_addr = fetch_en ? ADDR_W'(START_ADDR) : '0;
endmodule

// File: rtl/reset_boot_seq.sv
module reset_boot_seq #(
  parameter int unsigned HOLD_CYCLES = 2000,
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned START_ADDR  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por,
  input  logic              boot_strap,
  input  logic              bus_req,
  input  logic              boot_done,
  output logic              clr_stacks,
  output logic              mask_irqs,
  output logic              clr_mode,
  output logic              boot_start,
  output logic              fetch_en,
  output logic [ADDR_W-1:0] fetch_addr
);
  import rbs_pkg::*;

  seq_state_e seq_state;
  logic       lock_run;
  logic       hold_done;

  assign lock_run = (seq_state == ST_LOCK);

  rbs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(lock_run), .done(hold_done)
  );

  rbs_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .por(por), .boot_strap(boot_strap),
    .bus_req(bus_req), .boot_done(boot_done), .hold_done(hold_done),
    .state(seq_state)
  );

  rbs_out_decode #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_dec (
    .state(seq_state), .clr_stacks(clr_stacks), .mask_irqs(mask_irqs),
    .clr_mode(clr_mode), .boot_start(boot_start), .fetch_en(fetch_en),
    .fetch_addr(fetch_addr)
  );
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int unsigned HOLD_CYCLES = 2000,
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned START_ADDR  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por,
  input logic              boot_strap,
  input logic              bus_req,
  input logic              clr_stacks,
  input logic              mask_irqs,
  input logic              clr_mode,
  input logic              boot_start,
  input logic              fetch_en,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              hold_done
);
  int unsigned since_q;
  logic        cold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= 0;
      cold_q  <= 1'b0;
    end else begin
      if (since_q == 0) cold_q <= por;
      if (since_q < HOLD_CYCLES + 8) since_q <= since_q + 1;
    end
  end

  // R2
  cold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stacks && cold_q) |-> (since_q >= HOLD_CYCLES));
  // R2
  hold_to_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_done |=> clr_stacks);
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stacks |=> !clr_stacks);
  // R4
  strobe_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stacks == mask_irqs) && (clr_stacks == clr_mode));
  // R6
  boot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start |=> !boot_start);
  // R6
  boot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_start |-> ($past(!bus_req) && $past(!boot_strap)));
  // R9
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> fetch_en);
  // R9
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |-> (fetch_addr == ADDR_W'(START_ADDR)));
endmodule

bind reset_boot_seq rbs_checker #(
  .HOLD_CYCLES(HOLD_CYCLES), .ADDR_W(ADDR_W), .START_ADDR(START_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .por(por), .boot_strap(boot_strap),
  .bus_req(bus_req), .clr_stacks(clr_stacks), .mask_irqs(mask_irqs),
  .clr_mode(clr_mode), .boot_start(boot_start), .fetch_en(fetch_en),
  .fetch_addr(fetch_addr), .hold_done(hold_done)
);

// File: tb/tb_reset_boot_seq.sv
module tb_reset_boot_seq;
  localparam int HOLD = 2000;
  localparam int AW   = 14;

  logic clk = 1'b0, rst_n = 1'b0, por = 1'b1, boot_strap = 1'b0;
  logic bus_req = 1'b0, boot_done = 1'b0;
  logic clr_stacks, mask_irqs, clr_mode, boot_start, fetch_en;
  logic [AW-1:0] fetch_addr;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  reset_boot_seq #(.HOLD_CYCLES(HOLD), .ADDR_W(AW), .START_ADDR(0)) dut (
    .clk(clk), .rst_n(rst_n), .por(por), .boot_strap(boot_strap),
    .bus_req(bus_req), .boot_done(boot_done), .clr_stacks(clr_stacks),
    .mask_irqs(mask_irqs), .clr_mode(clr_mode), .boot_start(boot_start),
    .fetch_en(fetch_en), .fetch_addr(fetch_addr)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic enter_reset(bit p, bit s, bit b);
    @(negedge clk);
    rst_n = 1'b0; por = p; boot_strap = s; bus_req = b; boot_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset
    check("R1 outputs in reset",
          int'({clr_stacks, mask_irqs, clr_mode, boot_start, fetch_en}), 0);
    check("R1 fetch_addr in reset", int'(fetch_addr), 0);
  endtask

  // one reset release; expected cycle numbers come from the requirements
  task automatic run_case(bit p, bit s, int bh, int dd);
    int base, dec, kick_exp, fetch_exp;
    int strobe_at, kick_at, fetch_at, n_cs, n_mi, n_cm, n_kick, addr_ok;
    base = p ? HOLD + 1 : 1;                 // R2 / R3
    dec  = maxi(base, bh) + 1;               // R5
    kick_exp  = s ? -1 : dec;                // R6 / R8
    fetch_exp = s ? dec : dec + maxi(2, dd + 1); // R7 / R8
    enter_reset(p, s, (bh > 0));
    rst_n = 1'b1;
    strobe_at = -1; kick_at = -1; fetch_at = -1;
    n_cs = 0; n_mi = 0; n_cm = 0; n_kick = 0; addr_ok = 1;
    for (int k = 1; k <= fetch_exp + 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (clr_stacks) begin n_cs++; if (strobe_at < 0) strobe_at = k; end
      if (mask_irqs) n_mi++;
      if (clr_mode)  n_cm++;
      if (boot_start) begin n_kick++; if (kick_at < 0) kick_at = k; end
      if (fetch_en && fetch_at < 0) fetch_at = k;
      if (fetch_at > 0 && (!fetch_en || fetch_addr != '0)) addr_ok = 0;
      bus_req   = (k < bh);
      boot_done = !s && (k >= dec + dd);
    end
    check(p ? "R2 strobe cycle (cold)" : "R3 strobe cycle (warm)", strobe_at, base);
    check("R4 clr_stacks pulses", n_cs, 1);
    check("R4 mask_irqs pulses", n_mi, 1);
    check("R4 clr_mode pulses", n_cm, 1);
    check(s ? "R8 no boot_start" : "R6 boot_start cycle", kick_at, kick_exp);
    check("R6 boot_start count", n_kick, s ? 0 : 1);
    check(bh > 0 ? "R5 fetch after bus hold" : (s ? "R8 fetch cycle" : "R7 fetch cycle"),
          fetch_at, fetch_exp);
    check("R9 fetch held at address 0", addr_ok, 1);
  endtask

  // R10: asynchronous return to idle
  task automatic mid_reset(int stop_after);
    enter_reset(1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (stop_after) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check("R10 fetch_en dropped", int'(fetch_en), 0);
    check("R10 boot_start dropped", int'(boot_start), 0);
    check("R10 strobes dropped", int'({clr_stacks, mask_irqs, clr_mode}), 0);
  endtask

  initial begin
    for (int p = 1; p >= 0; p--)
      for (int s = 0; s < 2; s++)
        for (int b = 0; b < 2; b++)
          for (int d = 0; d < 2; d++)
            run_case(p[0], s[0], b ? ((p ? HOLD + 1 : 1) + 3) : 0, d ? 5 : 0);
    mid_reset(3);    // sits in boot wait (boot_done never comes)
    mid_reset(8);    // boot_done low: still waiting; cover a later point
    // reach fetch, then reset
    enter_reset(1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 fetch reached before reset", int'(fetch_en), 1);
    #2 rst_n = 1'b0;
    #1;
    check("R10 fetch_en dropped from fetch", int'(fetch_en), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule